// File: doc/BRIEF.md
# Delayed Tap Sample Fetch Sequencer

This block keeps a circular history of recent audio samples in on-chip memory and, once per audio sample period, produces a set of delayed taps from that history. A free-running sample clock arrives from outside, unrelated to the system clock. It is synchronized and its rising edges are detected. Each detected edge stores the newest sample and then fetches every tap in turn.

Each tap has a small unsigned delay code. The code is scaled by a fixed stride and gives how far back from the newest sample the tap reaches. The sequencer reads the taps one at a time, each through a request/ready exchange with the history memory. Each returned sample is placed in the tap register named by a load index.

A downstream gain or mixing stage reads the tap registers once the busy flag falls. An edge that comes while a pass is still running is dropped and recorded in a sticky overrun flag. With the defaults, samples are 24 bits wide, delay codes are 5 bits wide, the stride is 128 samples, the history holds 4096 entries and there are eight taps.

Top module: `tap_fetch_seq`

## Requirements
- R1: Each rising edge of `smp_clk_in` (after a two-flop synchronizer) starts exactly one pass while idle; a falling edge or a steady level starts nothing, and `busy` is high for the whole pass.
- R2: At the start of each pass `smp_data` (24 bits) is written into the history as the newest entry, and a tap whose delay code is 0 returns that same sample in that pass.
- R3: Tap t returns the sample written `code_t * 2**STRIDE_LOG2` passes before the newest one (128 by default, so at most 3968 back), with the history address wrapping modulo `2**DEPTH_LOG2`.
- R4: In each pass the taps are loaded strictly in order, index 0 to NUM_TAPS-1. There is exactly one `tap_load` pulse per tap, with `tap_idx` giving the index being loaded.
- R5: Every history read request is answered by a ready one cycle later, and at most one read is outstanding at a time.
- R6: A rising edge detected while `busy` is high stores no sample and starts no pass, and it sets `overrun`. Once set, `overrun` stays high until reset.
- R7: Synchronous active-low reset clears every tap register to 0, clears `overrun` and `busy`, and sets the history write position back to its start.
- R8: The delay code of tap t is `tap_codes[5t+4:5t]`, and tap t's sample appears on `tap_bus[24t+23:24t]`. Codes must remain stable while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_clk_in | input | 1 | Asynchronous audio sample clock |
| smp_data | input | 24 | Newest audio sample, stored at the start of a pass |
| tap_codes | input | 40 | Packed 5-bit delay codes, tap 0 in the low bits |
| tap_bus | output | 192 | Packed 24-bit tap registers, tap 0 in the low bits |
| tap_load | output | 1 | Pulses for one cycle as a tap register is loaded |
| tap_idx | output | 3 | Index of the tap being fetched or loaded |
| busy | output | 1 | A pass is running |
| overrun | output | 1 | Sticky flag: an edge was dropped during a pass |

## Verification
The bench runs a small configuration whose history just exceeds the longest reach, so the write position wraps many times. Codes 0 and the maximum are present in every pass. A wrong scaling or a wrong wrap would return samples from the wrong pass. An off-by-one write order would make code 0 return the previous sample. The order and count of load pulses are watched on every pass, which catches a skipped or repeated tap. A second edge is forced during a running pass, and the taps of the following pass are checked against the history. A design that did not drop that edge would have advanced the history twice and shifted every nonzero tap.

// File: rtl/tap_fetch_pkg.sv
// Package: shared types for the delayed tap fetch sequencer.
// Assumes nothing beyond standard SystemVerilog.
package tap_fetch_pkg;

    // Sequencer states: idle, issuing a read, awaiting the read result.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/tfs_edge_sync.sv
// Module: tfs_edge_sync
// Brings an asynchronous level into the clk domain through SYNC_STAGES
// flops and emits a one-cycle pulse on each synchronized rising edge.
// Assumes the input stays at each level for longer than SYNC_STAGES+1 cycles.
module tfs_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], async_in};
    end

    // Rising edge: newest synchronized level high, the one before low.
    assign rise = chain[CHAIN_W-2] & ~chain[CHAIN_W-1];

    // R1: an edge pulse lasts exactly one cycle.
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tfs_history_ram.sv
// Module: tfs_history_ram
// Circular sample history: one write port and one read port with a
// request/ready exchange. Ready follows a request by exactly one cycle.
// Assumes the sequencer never writes and reads in the same cycle.
// Contents are not reset; only the ready flag is.
module tfs_history_ram #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_rdy,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store array: write the newest sample; registered read on request.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_req) rd_data <= mem[rd_addr];
    end

    // Ready flag: mirrors the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_rdy <= 1'b0;
        else        rd_rdy <= rd_req;
    end

    // R5: a request is always answered on the next cycle.
    a_r5_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_rdy);

    // R2: writing and reading never collide in one cycle.
    a_r2_no_rw_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_req));

endmodule

// File: rtl/tfs_sequencer.sv
// Module: tfs_sequencer
// Per detected edge: writes the newest sample, then reads NUM_TAPS delayed
// taps one at a time, the address being the newest position minus
// code << STRIDE_LOG2 (modulo the history depth). It pulses a load strobe
// for each tap. Edges seen while busy are dropped and flagged.
// Assumes codes are stable while busy and ready arrives one cycle after a request.
module tfs_sequencer
    import tap_fetch_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int CODE_W      = 5,
    parameter int STRIDE_LOG2 = 7,
    parameter int ADDR_W      = 12,
    parameter int NUM_TAPS    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_evt,
    input  logic [DATA_W-1:0]          smp_in,
    input  logic [NUM_TAPS*CODE_W-1:0] codes_flat,
    input  logic                       rd_rdy,
    output logic                       wr_en,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       rd_req,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic                       tap_load,
    output logic [$clog2(NUM_TAPS)-1:0] tap_idx,
    output logic                       busy,
    output logic                       overrun
);
    localparam int IDX_W    = $clog2(NUM_TAPS);
    localparam int REACH_W  = CODE_W + STRIDE_LOG2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);

    seq_state_t          state;
    logic [ADDR_W-1:0]   head;
    logic [IDX_W-1:0]    idx;
    logic [CODE_W-1:0]   cur_code;
    logic [REACH_W-1:0]  reach;

    // Current tap's delay code and its distance back into the history.
    always_comb begin
        cur_code = codes_flat[int'(idx)*CODE_W +: CODE_W];
        reach    = {cur_code, {STRIDE_LOG2{1'b0}}};
    end

    // Memory-side and tap-side controls decoded from the state.
    assign wr_en    = start_evt && (state == SQ_IDLE);
    assign wr_addr  = head + 1'b1;
    assign wr_data  = smp_in;
    assign rd_req   = (state == SQ_REQ);
    assign rd_addr  = head - ADDR_W'(reach);
    assign tap_load = (state == SQ_WAIT) && rd_rdy;
    assign tap_idx  = idx;
    assign busy     = (state != SQ_IDLE);

    // Pass control: advance the write position, then step through the taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            head  <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start_evt) begin
                        head  <= head + 1'b1;
                        idx   <= '0;
                        state <= SQ_REQ;
                    end
                end
                SQ_REQ: state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rd_rdy) begin
                        if (idx == LAST_IDX) begin
                            state <= SQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SQ_REQ;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Overrun flag: set by an edge that lands during a pass, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (start_evt && busy)  overrun <= 1'b1;
    end

    // R6: overrun is sticky.
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5: a single outstanding read; requests are never back to back.
    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4: after a non-final load, the next load comes two cycles later with the next index.
    a_r4_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_load && (tap_idx != LAST_IDX)) |=> ##1
            (tap_load && (tap_idx == IDX_W'($past(tap_idx, 2) + 1'b1))));

    // R4: the final load of a pass ends it.
    a_r4_last_ends_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_load && (tap_idx == LAST_IDX)) |=> !busy);

    // R1: a pass begins with a write on the cycle it leaves idle.
    a_r1_start_writes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

endmodule

// File: rtl/tfs_tap_bank.sv
// Module: tfs_tap_bank
// NUM_TAPS registers of DATA_W bits; the register named by load_idx is
// loaded from load_data when load is high. All clear on reset.
// Assumes load_idx is below NUM_TAPS whenever load is high.
module tfs_tap_bank #(
    parameter int DATA_W   = 24,
    parameter int NUM_TAPS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [$clog2(NUM_TAPS)-1:0] load_idx,
    input  logic [DATA_W-1:0]           load_data,
    output logic [NUM_TAPS*DATA_W-1:0]  taps_flat
);
    localparam int IDX_W = $clog2(NUM_TAPS);

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        logic [DATA_W-1:0] tap_q;

        // Tap register t: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  tap_q <= '0;
            else if (load && (load_idx == IDX_W'(t)))    tap_q <= load_data;
        end

        assign taps_flat[t*DATA_W +: DATA_W] = tap_q;
    end

    // R4: only a valid index is ever loaded.
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (int'(load_idx) < NUM_TAPS));

endmodule

// File: rtl/tap_fetch_seq.sv
// Module: tap_fetch_seq (top)
// Delayed tap fetch: synchronizes the sample clock, stores one sample per
// rising edge in a circular history, and fetches NUM_TAPS delayed taps into
// a register bank. Requires the history to exceed the longest reach.
module tap_fetch_seq #(
    parameter int DATA_W      = 24,
    parameter int CODE_W      = 5,
    parameter int STRIDE_LOG2 = 7,
    parameter int DEPTH_LOG2  = 12,
    parameter int NUM_TAPS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_clk_in,
    input  logic [DATA_W-1:0]            smp_data,
    input  logic [NUM_TAPS*CODE_W-1:0]   tap_codes,
    output logic [NUM_TAPS*DATA_W-1:0]   tap_bus,
    output logic                         tap_load,
    output logic [$clog2(NUM_TAPS)-1:0]  tap_idx,
    output logic                         busy,
    output logic                         overrun
);
    localparam int IDX_W = $clog2(NUM_TAPS);

    logic              edge_evt;
    logic              wr_en;
    logic [DEPTH_LOG2-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_req;
    logic [DEPTH_LOG2-1:0] rd_addr;
    logic              rd_rdy;
    logic [DATA_W-1:0] rd_data;
    logic [IDX_W-1:0]  idx_w;

    tfs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (smp_clk_in),
        .rise     (edge_evt)
    );

    tfs_sequencer #(
        .DATA_W      (DATA_W),
        .CODE_W      (CODE_W),
        .STRIDE_LOG2 (STRIDE_LOG2),
        .ADDR_W      (DEPTH_LOG2),
        .NUM_TAPS    (NUM_TAPS)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (edge_evt),
        .smp_in     (smp_data),
        .codes_flat (tap_codes),
        .rd_rdy     (rd_rdy),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .tap_load   (tap_load),
        .tap_idx    (idx_w),
        .busy       (busy),
        .overrun    (overrun)
    );

    tfs_history_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (DEPTH_LOG2)
    ) i_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_rdy  (rd_rdy),
        .rd_data (rd_data)
    );

    tfs_tap_bank #(
        .DATA_W   (DATA_W),
        .NUM_TAPS (NUM_TAPS)
    ) i_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tap_load),
        .load_idx  (idx_w),
        .load_data (rd_data),
        .taps_flat (tap_bus)
    );

    assign tap_idx = idx_w;

    // R3: the longest reach must fit inside the history.
    initial begin
        a_r3_reach_fits: assert (((1 << CODE_W) - 1) * (1 << STRIDE_LOG2) < (1 << DEPTH_LOG2));
    end

    // R1: busy rises only right after a detected edge.
    a_r1_busy_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(edge_evt));

endmodule

// File: tb/test_tap_fetch_seq.sv
// Bench for tap_fetch_seq in a small configuration (stride 4, 128 entries)
// so the history wraps many times; expected taps come from a bench model.
module test_tap_fetch_seq;
    localparam int DW = 24;
    localparam int CW = 5;
    localparam int SL = 2;
    localparam int DL = 7;
    localparam int NT = 8;
    localparam int IW = $clog2(NT);
    localparam int NEV = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_clk_in = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [NT*CW-1:0] tap_codes = '0;
    logic [NT*DW-1:0] tap_bus;
    logic tap_load;
    logic [IW-1:0] tap_idx;
    logic busy;
    logic overrun;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int load_cnt = 0;
    int exp_idx = 0;
    int wr_count = 0;
    logic [DW-1:0] hist [0:1023];

    tap_fetch_seq #(
        .DATA_W(DW), .CODE_W(CW), .STRIDE_LOG2(SL),
        .DEPTH_LOG2(DL), .NUM_TAPS(NT), .SYNC_STAGES(2)
    ) i_tap_fetch_seq (
        .clk(clk), .rst_n(rst_n), .smp_clk_in(smp_clk_in),
        .smp_data(smp_data), .tap_codes(tap_codes), .tap_bus(tap_bus),
        .tap_load(tap_load), .tap_idx(tap_idx), .busy(busy), .overrun(overrun)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Load monitor (R4): order and count of tap loads, sampled off the edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && tap_load) begin
            check("R4 load index order", 32'(tap_idx), 32'(exp_idx));
            exp_idx++;
            load_cnt++;
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [CW-1:0] code_for(int ev, int t);
        if (t == 0) return '0;
        if (t == NT - 1) return '1;
        return CW'((t * 5 + ev * 3 + t * ev) % 32);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        smp_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wr_count = 0;
        @(negedge clk);
        // R7: reset state.
        check("R7 busy after reset", 32'(busy), 32'd0);
        check("R7 overrun after reset", 32'(overrun), 32'd0);
        for (int t = 0; t < NT; t++)
            check("R7 tap cleared", 32'(tap_bus[t*DW +: DW]), 32'd0);
    endtask

    // Raise the sample clock and wait for busy (R1).
    task automatic raise_and_wait_busy();
        int n;
        smp_clk_in = 1'b1;
        n = 0;
        while (!busy && n < 10) begin @(negedge clk); n++; end
        check("R1 pass starts on rising edge", 32'(busy), 32'd1);
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 60) begin @(negedge clk); n++; end
        check("R1 pass ends", 32'(busy), 32'd0);
    endtask

    // Compare every tap with the model (R2, R3, R8).
    task automatic check_taps(input int ev);
        for (int t = 0; t < NT; t++) begin
            int back;
            int j;
            back = int'(code_for(ev, t)) * (1 << SL);
            j = wr_count - back;
            if (j >= 1) begin
                if (back == 0)
                    check("R2 code 0 returns newest", 32'(tap_bus[t*DW +: DW]), 32'(hist[j]));
                else
                    check("R3 delayed tap value", 32'(tap_bus[t*DW +: DW]), 32'(hist[j]));
            end
        end
    endtask

    task automatic set_inputs(input int ev, input logic [DW-1:0] s);
        smp_data = s;
        for (int t = 0; t < NT; t++) tap_codes[t*CW +: CW] = code_for(ev, t);
    endtask

    // One full pass: edge, fetch, compare.
    task automatic one_event(input int ev, input logic [DW-1:0] s);
        set_inputs(ev, s);
        @(negedge clk);
        load_cnt = 0;
        exp_idx = 0;
        raise_and_wait_busy();
        wait_idle();
        wr_count++;
        hist[wr_count] = s;
        check("R4 one load per tap", 32'(load_cnt), 32'(NT));
        smp_clk_in = 1'b0;
        repeat (5) @(negedge clk);
        // R1: the falling edge starts nothing.
        check("R1 no pass on falling edge", 32'(busy), 32'd0);
        check_taps(ev);
    endtask

    initial begin
        do_reset();
        for (int ev = 0; ev < NEV; ev++)
            one_event(ev, DW'(32'h5A3C00 ^ (ev * 32'h010307)));
        check("R6 no overrun in normal use", 32'(overrun), 32'd0);

        // R6: second edge during a pass is dropped and flagged.
        set_inputs(NEV, 24'hABCDEF);
        @(negedge clk);
        load_cnt = 0;
        exp_idx = 0;
        raise_and_wait_busy();
        smp_clk_in = 1'b0;
        repeat (4) @(negedge clk);
        smp_clk_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 still busy at extra edge", 32'(busy), 32'd1);
        wait_idle();
        wr_count++;
        hist[wr_count] = 24'hABCDEF;
        check("R6 overrun set", 32'(overrun), 32'd1);
        check("R6 dropped edge loads nothing extra", 32'(load_cnt), 32'(NT));
        smp_clk_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R6 no pass from dropped edge", 32'(busy), 32'd0);
        check_taps(NEV);
        // Next pass shows the history advanced only once.
        one_event(NEV + 1, 24'h123456);
        check("R6 overrun sticky", 32'(overrun), 32'd1);

        // R7: reset clears flag and taps, then operation resumes.
        do_reset();
        for (int ev = 0; ev < 40; ev++)
            one_event(ev + 7, DW'(32'h00F00D + ev * 32'h0A0B));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule